// File: doc/BRIEF.md
# Matrix Keypad Capture Register Block

This block is the software-visible register file of a matrix keypad controller. Key events arrive one at a time on a small event port. Each event carries a row, a column, and whether the key went down or came back up. When the controller is enabled and one of its two scan modes is armed, the event is folded into one of four capture registers. Each capture register covers a pair of adjacent columns. After a capture the block can raise a level interrupt.

Software reaches ten 32-bit registers over a simple synchronous bus. Reads are registered, so the data appears one cycle after the read strobe. Reading the control register, the rotary status register or the matrix-key register returns the value held before the read and clears that register's sticky status bits in the same cycle. A read of the control register also drops the interrupt. Scanning the physical lines, debouncing and rotary counting happen elsewhere; the registers that belong to them are plain storage here.

Top module: `keymatrix_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Registers are word-aligned at byte offsets 0x00 (control), 0x08 (direct key), 0x10 (rotary), 0x18 (matrix key), 0x20 (scan status), 0x28/0x30/0x38/0x40 (capture 0..3) and 0x48 (debounce). A write stores all 32 bits, status bits included, and a later read returns them.
- R3: A key event has no effect on any register or on `irq` unless control bit 12 (matrix enable) is set.
- R4: An event is captured only if control bit 30 (single scan) or bit 29 (scan on activity) is set. A capture clears bit 30.
- R5: A captured press sets bit `row + 16*(col mod 2)` of capture register `col/2` and keeps the bits already set.
- R6: A captured release clears the whole capture register of that column pair and leaves the other three unchanged.
- R7: A capture with control bit 11 (interrupt enable) set sets control bit 22 (matrix flag) and drives `irq` high on the next cycle. Without bit 11, neither changes.
- R8: A control read returns the pre-read value, then clears bits 22 and 5 and drives `irq` low.
- R9: A rotary read clears bits 31, 30, 15 and 14. A matrix-key read clears bit 31. Both return the value as it was before the clear.
- R10: A read of an unaligned offset or an offset above 0x48 returns zero and changes no state.
- R11: When a bus write and a key event target the same register in the same cycle, the written value is what remains.
- R12: `bus_rdata` holds the read result from the cycle after `bus_rd` until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| key_valid | input | 1 | Key event present this cycle |
| key_release | input | 1 | 1 = release, 0 = press |
| key_row | input | 3 | Row of the key |
| key_col | input | 3 | Column of the key |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives presses in both columns of one pair and checks that they accumulate. It then releases a key in that pair and checks that only that pair is wiped, so a design that clears a single bit, or all four registers, is caught. Repeated reads of the clear-on-read registers show the old value first and the cleared value second; a design that clears before returning, or clears the wrong bits, fails on one of the two reads. Events with matrix enable clear, with no scan mode armed, and with interrupt enable clear must leave the registers and `irq` untouched, and a design that drops a guard shows up there. Two further cases are covered. An event and a write on the same capture register must keep the written value. A single-scan capture must disarm itself, so a second event is ignored.

// File: rtl/keymatrix_pkg.sv
package keymatrix_pkg;
  localparam int DATA_W    = 32;
  localparam int ROW_W     = 3;
  localparam int COL_W     = 3;
  localparam int HALF_W    = 16;
  localparam int NUM_BANKS = (1 << COL_W) / 2;
  localparam int NUM_REGS  = 6 + NUM_BANKS;

  // register indices (byte offset = index * 8)
  localparam int IDX_CTRL  = 0;
  localparam int IDX_DKEY  = 1;
  localparam int IDX_ROT   = 2;
  localparam int IDX_MKEY  = 3;
  localparam int IDX_SCAN  = 4;
  localparam int IDX_BANK0 = 5;
  localparam int IDX_DEB   = IDX_BANK0 + NUM_BANKS;

  // control bit positions
  localparam int B_SINGLE  = 30;
  localparam int B_ACTSCAN = 29;
  localparam int B_MFLAG   = 22;
  localparam int B_MEN     = 12;
  localparam int B_MIE     = 11;
  localparam int B_DFLAG   = 5;

  localparam logic [DATA_W-1:0] ROT_CLR_MASK  = 32'hC000_C000;
  localparam logic [DATA_W-1:0] MKEY_CLR_MASK = 32'h8000_0000;
endpackage

// File: rtl/kmx_event_decode.sv
module kmx_event_decode
  import keymatrix_pkg::*;
(
  input  logic                 key_valid,
  input  logic [ROW_W-1:0]     key_row,
  input  logic [COL_W-1:0]     key_col,
  input  logic [DATA_W-1:0]    ctrl,
  output logic                 capture,
  output logic [NUM_BANKS-1:0] bank_hit,
  output logic [DATA_W-1:0]    set_mask
);
  logic armed;
  logic [$clog2(DATA_W)-1:0] bit_pos;

  always_comb begin
    armed    = ctrl[B_SINGLE] | ctrl[B_ACTSCAN];
    capture  = key_valid & ctrl[B_MEN] & armed;
    bit_pos  = {{($clog2(DATA_W)-ROW_W){1'b0}}, key_row}
             + (key_col[0] ? $clog2(DATA_W)'(HALF_W) : '0);
    set_mask = '0;
    set_mask[bit_pos] = 1'b1;
    bank_hit = '0;
    if (capture) bank_hit[key_col[COL_W-1:1]] = 1'b1;
  end
endmodule

// File: rtl/kmx_capture_bank.sv
module kmx_capture_bank
  import keymatrix_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ev_hit,
  input  logic              ev_release,
  input  logic [DATA_W-1:0] ev_mask,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (wr_en)   q <= wr_data;
    else if (ev_hit)  q <= ev_release ? '0 : (q | ev_mask);
  end
endmodule

// File: rtl/kmx_read_mux.sv
module kmx_read_mux
  import keymatrix_pkg::*;
#(
  parameter int ADDR_W = 8
)(
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] regs [NUM_REGS],
  output logic [DATA_W-1:0] data
);
  localparam int IDX_W = ADDR_W - 3;
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx  = addr[ADDR_W-1:3];
    data = '0;
    if (addr[2:0] == 3'b000) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (idx == IDX_W'(i)) data = regs[i];
    end
  end
endmodule

// File: rtl/keymatrix_ctrl.sv
module keymatrix_ctrl
  import keymatrix_pkg::*;
#(
  parameter int ADDR_W = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic              key_valid,
  input  logic              key_release,
  input  logic [2:0]        key_row,
  input  logic [2:0]        key_col,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 3;

  logic [NUM_REGS-1:0]  wr_sel, rd_sel;
  logic [DATA_W-1:0]    regs [NUM_REGS];
  logic [DATA_W-1:0]    ctrl_q, dkey_q, rot_q, mkey_q, scan_q, deb_q;
  logic [DATA_W-1:0]    bank_q [NUM_BANKS];
  logic [DATA_W*NUM_BANKS-1:0] bank_flat;
  logic                 capture;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [DATA_W-1:0]    set_mask;
  logic [DATA_W-1:0]    rd_data;

  // one-hot register select for reads and writes
  always_comb begin
    wr_sel = '0;
    rd_sel = '0;
    if (bus_addr[2:0] == 3'b000) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (bus_addr[ADDR_W-1:3] == IDX_W'(i)) begin
          wr_sel[i] = bus_wr;
          rd_sel[i] = bus_rd;
        end
      end
    end
  end

  kmx_event_decode u_dec (
    .key_valid (key_valid),
    .key_row   (key_row),
    .key_col   (key_col),
    .ctrl      (ctrl_q),
    .capture   (capture),
    .bank_hit  (bank_hit),
    .set_mask  (set_mask)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      kmx_capture_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_sel[IDX_BANK0+b]),
        .wr_data    (bus_wdata),
        .ev_hit     (bank_hit[b]),
        .ev_release (key_release),
        .ev_mask    (set_mask),
        .q          (bank_q[b])
      );
      assign regs[IDX_BANK0+b] = bank_q[b];
      assign bank_flat[b*DATA_W +: DATA_W] = bank_q[b];
    end
  endgenerate

  // control: read-clear, then capture effects, then write wins
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_sel[IDX_CTRL]) begin
      ctrl_q <= bus_wdata;
    end else begin
      logic [DATA_W-1:0] nx;
      nx = ctrl_q;
      if (rd_sel[IDX_CTRL]) begin
        nx[B_MFLAG] = 1'b0;
        nx[B_DFLAG] = 1'b0;
      end
      if (capture) begin
        nx[B_SINGLE] = 1'b0;
        if (ctrl_q[B_MIE]) nx[B_MFLAG] = 1'b1;
      end
      ctrl_q <= nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                          irq <= 1'b0;
    else if (capture && ctrl_q[B_MIE]) irq <= 1'b1;
    else if (rd_sel[IDX_CTRL])        irq <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dkey_q <= '0;
      rot_q  <= '0;
      mkey_q <= '0;
      scan_q <= '0;
      deb_q  <= '0;
    end else begin
      if (wr_sel[IDX_DKEY]) dkey_q <= bus_wdata;
      if (wr_sel[IDX_SCAN]) scan_q <= bus_wdata;
      if (wr_sel[IDX_DEB])  deb_q  <= bus_wdata;
      if (wr_sel[IDX_ROT])       rot_q <= bus_wdata;
      else if (rd_sel[IDX_ROT])  rot_q <= rot_q & ~ROT_CLR_MASK;
      if (wr_sel[IDX_MKEY])      mkey_q <= bus_wdata;
      else if (rd_sel[IDX_MKEY]) mkey_q <= mkey_q & ~MKEY_CLR_MASK;
    end
  end

  assign regs[IDX_CTRL] = ctrl_q;
  assign regs[IDX_DKEY] = dkey_q;
  assign regs[IDX_ROT]  = rot_q;
  assign regs[IDX_MKEY] = mkey_q;
  assign regs[IDX_SCAN] = scan_q;
  assign regs[IDX_DEB]  = deb_q;

  kmx_read_mux #(.ADDR_W(ADDR_W)) u_rmux (
    .addr (bus_addr),
    .regs (regs),
    .data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_data;
  end
endmodule

// File: rtl/keymatrix_ctrl_checker.sv
module keymatrix_ctrl_checker
  import keymatrix_pkg::*;
#(
  parameter int ADDR_W = 8
)(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic              key_valid,
  input logic              irq,
  input logic [31:0]       ctrl_q,
  input logic [32*NUM_BANKS-1:0] bank_flat
);
  logic unmapped;
  logic ctrl_rd;
  assign unmapped = (bus_addr[2:0] != 3'b000) ||
                    (int'(bus_addr[ADDR_W-1:3]) >= NUM_REGS);
  assign ctrl_rd  = bus_rd && (bus_addr == '0);

  // R7: irq only rises after a key event
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(key_valid));

  // R8: control read without a concurrent event leaves irq low
  assert_ctrl_read_drops_irq_R8: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_rd && !key_valid) |-> !irq);

  // R10: unmapped reads return zero
  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (rst)
    $past(bus_rd && unmapped) |-> (bus_rdata == 32'h0));

  // R3: with matrix enable clear, events leave capture state alone
  assert_disabled_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (key_valid && !ctrl_q[B_MEN] && !bus_wr) |=> $stable(bank_flat));

  // R4: a single-scan capture disarms itself
  assert_single_scan_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (key_valid && ctrl_q[B_MEN] && ctrl_q[B_SINGLE] && !bus_wr) |=> !ctrl_q[B_SINGLE]);
endmodule

bind keymatrix_ctrl keymatrix_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .key_valid (key_valid),
  .irq       (irq),
  .ctrl_q    (ctrl_q),
  .bank_flat (bank_flat)
);

// File: tb/keymatrix_ctrl_tb.sv
module keymatrix_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        key_valid = 1'b0;
  logic        key_release = 1'b0;
  logic [2:0]  key_row = '0;
  logic [2:0]  key_col = '0;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  keymatrix_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .key_valid(key_valid), .key_release(key_release),
    .key_row(key_row), .key_col(key_col), .irq(irq)
  );

  // ops: 0 write, 1 read+check, 2 key event (data: [8]=release [5:3]=col [2:0]=row)
  // entry = {op[1:0], addr[7:0], data[31:0], expect[31:0], req[5:0]}
  localparam int NV = 26;
  localparam logic [79:0] VEC [NV] = '{
    {2'd0, 8'h00, 32'h4000_1800, 32'h0,         6'd2},  // ctrl: single scan, enable, irq enable
    {2'd2, 8'h00, 32'h0000_002B, 32'h0,         6'd5},  // press row3 col5
    {2'd1, 8'h38, 32'h0,         32'h0008_0000, 6'd5},  // R5 bank2 bit19
    {2'd1, 8'h00, 32'h0,         32'h0040_1800, 6'd4},  // R4 single cleared, R7 flag set
    {2'd1, 8'h00, 32'h0,         32'h0000_1800, 6'd8},  // R8 flag cleared by read
    {2'd2, 8'h00, 32'h0000_0028, 32'h0,         6'd4},  // press r0 c5, no scan armed
    {2'd1, 8'h38, 32'h0,         32'h0008_0000, 6'd4},  // R4 ignored
    {2'd0, 8'h00, 32'h2000_1800, 32'h0,         6'd2},  // scan on activity
    {2'd2, 8'h00, 32'h0000_0027, 32'h0,         6'd5},  // press r7 c4
    {2'd2, 8'h00, 32'h0000_0001, 32'h0,         6'd5},  // press r1 c0
    {2'd1, 8'h38, 32'h0,         32'h0008_0080, 6'd5},  // R5 accumulate
    {2'd1, 8'h28, 32'h0,         32'h0000_0002, 6'd5},  // R5 bank0
    {2'd2, 8'h00, 32'h0000_012A, 32'h0,         6'd6},  // release r2 c5
    {2'd1, 8'h38, 32'h0,         32'h0000_0000, 6'd6},  // R6 wiped
    {2'd1, 8'h28, 32'h0,         32'h0000_0002, 6'd6},  // R6 other bank kept
    {2'd0, 8'h10, 32'hFFFF_FFFF, 32'h0,         6'd2},
    {2'd1, 8'h10, 32'h0,         32'hFFFF_FFFF, 6'd9},  // R9 old value
    {2'd1, 8'h10, 32'h0,         32'h3FFF_3FFF, 6'd9},  // R9 cleared
    {2'd0, 8'h18, 32'h8000_0005, 32'h0,         6'd2},
    {2'd1, 8'h18, 32'h0,         32'h8000_0005, 6'd9},
    {2'd1, 8'h18, 32'h0,         32'h0000_0005, 6'd9},
    {2'd1, 8'h50, 32'h0,         32'h0000_0000, 6'd10}, // R10 above map
    {2'd1, 8'h04, 32'h0,         32'h0000_0000, 6'd10}, // R10 unaligned
    {2'd0, 8'h48, 32'h0000_1234, 32'h0,         6'd2},
    {2'd1, 8'h48, 32'h0,         32'h0000_1234, 6'd2},  // R2 debounce
    {2'd1, 8'h08, 32'h0,         32'h0000_0000, 6'd2}   // R2 direct key untouched
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic ev(input logic rel, input logic [2:0] r, input logic [2:0] c);
    @(negedge clk); key_valid = 1'b1; key_release = rel; key_row = r; key_col = c;
    @(negedge clk); key_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 10; i++) begin
      rd(8'(i * 8), v);
      check("R1 reg", v, 32'h0);
    end

    // R12 timing is implied by every read below (sampled one cycle after strobe)
    for (int k = 0; k < NV; k++) begin
      logic [79:0] e;
      e = VEC[k];
      case (e[79:78])
        2'd0: wr(e[77:70], e[69:38]);
        2'd1: begin
          rd(e[77:70], v);
          check($sformatf("R%0d vec%0d", e[5:0], k), v, e[37:6]);
        end
        default: ev(e[46], e[40:38], e[43:41]);
      endcase
    end

    // R7: irq after capture, R8: dropped by control read
    wr(8'h00, 32'h2000_1800);
    ev(1'b0, 3'd5, 3'd6);
    check("R7 irq high", {31'b0, irq}, 32'h1);
    rd(8'h40, v);
    check("R5 bank3 bit5", v, 32'h0000_0020);
    rd(8'h00, v);
    check("R8 irq low", {31'b0, irq}, 32'h0);

    // R7: interrupt enable clear, no flag and no irq
    wr(8'h00, 32'h2000_1000);
    ev(1'b0, 3'd6, 3'd7);
    check("R7 no irq", {31'b0, irq}, 32'h0);
    rd(8'h00, v);
    check("R7 no flag", v, 32'h2000_1000);
    rd(8'h40, v);
    check("R5 bank3 col7", v, 32'h0040_0020);

    // R3: matrix enable clear, event ignored
    wr(8'h00, 32'h4000_0800);
    ev(1'b1, 3'd0, 3'd6);
    rd(8'h40, v);
    check("R3 bank kept", v, 32'h0040_0020);
    rd(8'h00, v);
    check("R3 ctrl kept", v, 32'h4000_0800);
    check("R3 irq low", {31'b0, irq}, 32'h0);

    // R11: write and event on the same capture register
    wr(8'h00, 32'h2000_1000);
    @(negedge clk);
    bus_addr = 8'h28; bus_wdata = 32'h0000_0011; bus_wr = 1'b1;
    key_valid = 1'b1; key_release = 1'b0; key_row = 3'd4; key_col = 3'd1;
    @(negedge clk);
    bus_wr = 1'b0; key_valid = 1'b0;
    rd(8'h28, v);
    check("R11 write wins", v, 32'h0000_0011);

    // R10: unmapped read leaves state alone
    rd(8'h51, v);
    check("R10 zero", v, 32'h0);
    rd(8'h28, v);
    check("R10 no side effect", v, 32'h0000_0011);

    // R12: rdata holds between reads
    repeat (3) @(negedge clk);
    check("R12 hold", bus_rdata, 32'h0000_0011);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule